// File: doc/BRIEF.md
# Ethernet interface clock generator

This block produces the timing signals that the Ethernet side of a device needs. Two clocks come in: a continuous system clock (nominally 100 MHz) and a packet reference clock (25 MHz in MII mode, 50 MHz in RMII mode). Three strap-like mode inputs pick the clocking arrangement:

- RMII or MII.
- Clock master (DCE) or clock slave (DTE).
- 10 or 100 Mbit/s.

The outputs follow from that choice. A reference output is the system clock divided by 2 in RMII mode and by 4 in MII mode, so it can feed the reference clock input back and save an oscillator. A management data clock is the system clock divided by 60 in every mode. In MII DCE mode the block also produces a transmit/receive clock pair from the reference clock. At 100 Mbit/s that pair runs at the reference rate. At 10 Mbit/s it runs at one tenth of the reference rate.

Output-enable flags tell the pad ring whether the transmit/receive clock pins are driven. They are driven only in MII DCE mode. In DTE mode the PHY supplies those clocks. In RMII mode they are not used at all. The mode inputs are synchronised separately into each clock domain. Any change restarts the affected divider from zero, so that the new ratio starts on a clean, low output.

Top module: `eth_clkgen`

## Requirements
- R1: `refo_clk` is high for 1 system-clock cycle and low for 1 when `rmii_sel`=1 (divide by 2). It is high for 2 and low for 2 when `rmii_sel`=0 (divide by 4). `dce_sel` and `fast_sel` have no effect on it.
- R2: `mdc_clk` is high for exactly 30 system-clock cycles and low for exactly 30 in every mode (divide by 60, 50% duty).
- R3: With `rmii_sel`=0, `dce_sel`=1 and `fast_sel`=1, `txc_o` and `rxc_o` equal `ref_clk`: high while it is high, low while it is low. With `fast_sel`=0 they are high for 5 `ref_clk` cycles and low for 5 (divide by 10). `rxc_o` always equals `txc_o`.
- R4: `txc_oe` and `rxc_oe` are 1 only when `rmii_sel`=0 and `dce_sel`=1. They are 0 in DTE mode (`dce_sel`=0) and in RMII mode (`rmii_sel`=1), whatever the speed.
- R5: While the output enables are 0, `txc_o` and `rxc_o` stay low.
- R6: While the synchronous reset `rst` is high, all clock outputs are low and both output enables are 0, one edge after `rst` is sampled in the respective domain.
- R7: When the transmit/receive clocks are enabled again after being off, their divider starts from zero. The output stays low until a full half period has passed, and every high pulse that follows lasts the full 5 cycles at 10 Mbit/s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Continuous system clock (nominal 100 MHz) |
| ref_clk | input | 1 | Packet reference clock (25 MHz MII, 50 MHz RMII) |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| rmii_sel | input | 1 | 1 = RMII, 0 = MII |
| dce_sel | input | 1 | 1 = clock master (DCE), 0 = clock slave (DTE) |
| fast_sel | input | 1 | 1 = 100 Mbit/s, 0 = 10 Mbit/s |
| refo_clk | output | 1 | System clock divided by 2 (RMII) or 4 (MII) |
| mdc_clk | output | 1 | System clock divided by 60 |
| txc_o | output | 1 | Transmit clock output in MII DCE mode |
| rxc_o | output | 1 | Receive clock output in MII DCE mode |
| txc_oe | output | 1 | Drive enable for the transmit clock pin |
| rxc_oe | output | 1 | Drive enable for the receive clock pin |

## Verification
A mode change reaches the outputs only after the synchroniser stages and one compare register in each domain, so a new ratio is due about three cycles of the affected clock later. The reset state is due one edge after `rst` is sampled. The bench never checks inside that window: after each mode change it waits a settle time well beyond the latency, and only then measures pulse widths. It samples one nanosecond after the active edge of the clock that owns the output, and it counts only pulses whose rising and falling edges both fall inside the observation window. The pass-through mode is checked at mid-phase of `ref_clk`, because that output follows the reference clock level rather than an edge.

// File: rtl/eth_clkgen_pkg.sv
package eth_clkgen_pkg;

   typedef struct packed {
      logic rmii;
      logic dce;
      logic fast;
   } eth_mode_t;

   localparam int MODE_W = $bits(eth_mode_t);

   function automatic logic drives_txrx(eth_mode_t m);
      return !m.rmii && m.dce;
   endfunction

   function automatic int max2(int a, int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/eth_clkgen_sync.sv
module eth_clkgen_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk) begin
            if (rst) begin
               for (int i = 0; i < STAGES; i++) st[i] <= '0;
            end else begin
               st[0] <= d;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/eth_clkgen_div.sv
module eth_clkgen_div #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          restart,
   input  logic          run,
   input  logic [CW-1:0] half,
   output logic          q
);

   logic [CW-1:0] cnt;
   logic          wrap;

   assign wrap = (cnt == half - 1'b1);

   always_ff @(posedge clk) begin
      if (rst || restart || !run) begin
         cnt <= '0;
         q   <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         q   <= ~q;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/eth_clkgen.sv
module eth_clkgen
   import eth_clkgen_pkg::*;
#(
   parameter int REFO_HALF_RMII = 1,
   parameter int REFO_HALF_MII  = 2,
   parameter int MDC_HALF       = 30,
   parameter int TXC_SLOW_HALF  = 5,
   parameter int TXC_FAST_HALF  = 0,
   parameter int SYNC_STAGES    = 2
) (
   input  logic sys_clk,
   input  logic ref_clk,
   input  logic rst,
   input  logic rmii_sel,
   input  logic dce_sel,
   input  logic fast_sel,
   output logic refo_clk,
   output logic mdc_clk,
   output logic txc_o,
   output logic rxc_o,
   output logic txc_oe,
   output logic rxc_oe
);

   localparam int REFO_MAX = max2(REFO_HALF_RMII, REFO_HALF_MII);
   localparam int RCW      = $clog2(REFO_MAX + 1);
   localparam int MCW      = $clog2(MDC_HALF + 1);
   localparam int TXC_MAX  = max2(TXC_SLOW_HALF, TXC_FAST_HALF);
   localparam int TCW      = $clog2(TXC_MAX + 1);

   generate
      if (REFO_HALF_RMII < 1 || REFO_HALF_MII < 1) begin : g_bad_refo
         $error("eth_clkgen: reference output half periods must be at least 1");
      end
      if (MDC_HALF < 1) begin : g_bad_mdc
         $error("eth_clkgen: management clock half period must be at least 1");
      end
      if (TXC_SLOW_HALF < 1 || TXC_FAST_HALF < 0) begin : g_bad_txc
         $error("eth_clkgen: transmit/receive clock half periods out of range");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("eth_clkgen: synchroniser depth cannot be negative");
      end
   endgenerate

   // ---------------- system clock domain ----------------
   logic sys_rmii_s;
   logic sys_rmii_q;
   logic sys_restart;
   logic [RCW-1:0] refo_half;

   eth_clkgen_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sys_sync (
      .clk (sys_clk),
      .rst (rst),
      .d   (rmii_sel),
      .q   (sys_rmii_s)
   );

   always_ff @(posedge sys_clk) begin
      if (rst) sys_rmii_q <= 1'b0;
      else     sys_rmii_q <= sys_rmii_s;
   end

   assign sys_restart = (sys_rmii_s != sys_rmii_q);
   assign refo_half   = sys_rmii_q ? RCW'(REFO_HALF_RMII) : RCW'(REFO_HALF_MII);

   eth_clkgen_div #(.CW(RCW)) u_refo (
      .clk     (sys_clk),
      .rst     (rst),
      .restart (sys_restart),
      .run     (1'b1),
      .half    (refo_half),
      .q       (refo_clk)
   );

   eth_clkgen_div #(.CW(MCW)) u_mdc (
      .clk     (sys_clk),
      .rst     (rst),
      .restart (1'b0),
      .run     (1'b1),
      .half    (MCW'(MDC_HALF)),
      .q       (mdc_clk)
   );

   // ---------------- reference clock domain ----------------
   eth_mode_t mode_raw;
   eth_mode_t mode_s;
   eth_mode_t mode_q;
   logic      ref_restart;
   logic      ref_drive;
   logic      slow_clk;
   logic      fast_clk;

   assign mode_raw = '{rmii: rmii_sel, dce: dce_sel, fast: fast_sel};

   eth_clkgen_sync #(.W(MODE_W), .STAGES(SYNC_STAGES)) u_ref_sync (
      .clk (ref_clk),
      .rst (rst),
      .d   (mode_raw),
      .q   (mode_s)
   );

   always_ff @(posedge ref_clk) begin
      if (rst) mode_q <= '0;
      else     mode_q <= mode_s;
   end

   assign ref_restart = (mode_s != mode_q);
   assign ref_drive   = drives_txrx(mode_q);

   eth_clkgen_div #(.CW(TCW)) u_txc_slow (
      .clk     (ref_clk),
      .rst     (rst),
      .restart (ref_restart),
      .run     (ref_drive && !mode_q.fast),
      .half    (TCW'(TXC_SLOW_HALF)),
      .q       (slow_clk)
   );

   generate
      if (TXC_FAST_HALF == 0) begin : g_pass
         logic gate_q;
         always_ff @(negedge ref_clk) begin
            if (rst) gate_q <= 1'b0;
            else     gate_q <= ref_drive && mode_q.fast;
         end
         assign fast_clk = ref_clk & gate_q;
      end else begin : g_fdiv
         eth_clkgen_div #(.CW(TCW)) u_txc_fast (
            .clk     (ref_clk),
            .rst     (rst),
            .restart (ref_restart),
            .run     (ref_drive && mode_q.fast),
            .half    (TCW'(TXC_FAST_HALF)),
            .q       (fast_clk)
         );
      end
   endgenerate

   assign txc_o  = slow_clk | fast_clk;
   assign rxc_o  = slow_clk | fast_clk;
   assign txc_oe = ref_drive;
   assign rxc_oe = ref_drive;

endmodule

// File: rtl/eth_clkgen_chk.sv
module eth_clkgen_chk #(
   parameter int REFO_MAX = 2,
   parameter int MDC_HALF = 30
) (
   input logic sys_clk,
   input logic ref_clk,
   input logic rst,
   input logic sys_restart,
   input logic refo_clk,
   input logic mdc_clk,
   input logic txc_o,
   input logic rxc_o,
   input logic txc_oe
);

   logic [15:0] refo_hrun;
   logic [15:0] mdc_hrun;
   logic [15:0] mdc_lrun;

   always_ff @(posedge sys_clk) begin
      if (rst || sys_restart) refo_hrun <= '0;
      else if (refo_clk)      refo_hrun <= refo_hrun + 1'b1;
      else                    refo_hrun <= '0;
   end

   always_ff @(posedge sys_clk) begin
      if (rst) begin
         mdc_hrun <= '0;
         mdc_lrun <= '0;
      end else if (mdc_clk) begin
         mdc_hrun <= mdc_hrun + 1'b1;
         mdc_lrun <= '0;
      end else begin
         mdc_hrun <= '0;
         mdc_lrun <= mdc_lrun + 1'b1;
      end
   end

   AST_REFO_HIGH_BOUND: assert property (@(posedge sys_clk) disable iff (rst)
      refo_hrun <= 16'(REFO_MAX)); // R1

   AST_MDC_HIGH_BOUND: assert property (@(posedge sys_clk) disable iff (rst)
      mdc_hrun <= 16'(MDC_HALF)); // R2

   AST_MDC_LOW_BOUND: assert property (@(posedge sys_clk) disable iff (rst)
      mdc_lrun <= 16'(MDC_HALF)); // R2

   AST_TXRX_QUIET_UNDRIVEN: assert property (@(posedge ref_clk) disable iff (rst)
      !txc_oe |-> (!txc_o && !rxc_o)); // R5

   AST_SYS_RESET_LOW: assert property (@(posedge sys_clk)
      rst |=> (!refo_clk && !mdc_clk)); // R6

   AST_REF_RESET_OFF: assert property (@(posedge ref_clk)
      rst |=> !txc_oe); // R6

endmodule

bind eth_clkgen eth_clkgen_chk #(
   .REFO_MAX (REFO_MAX),
   .MDC_HALF (MDC_HALF)
) u_chk (
   .sys_clk     (sys_clk),
   .ref_clk     (ref_clk),
   .rst         (rst),
   .sys_restart (sys_restart),
   .refo_clk    (refo_clk),
   .mdc_clk     (mdc_clk),
   .txc_o       (txc_o),
   .rxc_o       (rxc_o),
   .txc_oe      (txc_oe)
);

// File: tb/tb_eth_clkgen.sv
module tb_eth_clkgen;

   logic sys_clk = 1'b0;
   logic ref_clk = 1'b0;
   logic rst = 1'b1;
   logic rmii_sel = 1'b0;
   logic dce_sel = 1'b1;
   logic fast_sel = 1'b0;
   logic refo_clk, mdc_clk, txc_o, rxc_o, txc_oe, rxc_oe;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 sys_clk = ~sys_clk;
   always #5 ref_clk = ~ref_clk;

   eth_clkgen dut (
      .sys_clk  (sys_clk),
      .ref_clk  (ref_clk),
      .rst      (rst),
      .rmii_sel (rmii_sel),
      .dce_sel  (dce_sel),
      .fast_sel (fast_sel),
      .refo_clk (refo_clk),
      .mdc_clk  (mdc_clk),
      .txc_o    (txc_o),
      .rxc_o    (rxc_o),
      .txc_oe   (txc_oe),
      .rxc_oe   (rxc_oe)
   );

   // txc_kind: 0 = off, 15 = follows ref_clk, otherwise half period in ref cycles
   typedef struct packed {
      logic       rmii;
      logic       dce;
      logic       fast;
      logic [3:0] refo_half;
      logic       oe;
      logic [3:0] txc_kind;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{rmii: 1'b1, dce: 1'b0, fast: 1'b0, refo_half: 4'd1, oe: 1'b0, txc_kind: 4'd0},
      '{rmii: 1'b1, dce: 1'b1, fast: 1'b1, refo_half: 4'd1, oe: 1'b0, txc_kind: 4'd0},
      '{rmii: 1'b0, dce: 1'b0, fast: 1'b1, refo_half: 4'd2, oe: 1'b0, txc_kind: 4'd0},
      '{rmii: 1'b0, dce: 1'b1, fast: 1'b1, refo_half: 4'd2, oe: 1'b1, txc_kind: 4'd15},
      '{rmii: 1'b0, dce: 1'b1, fast: 1'b0, refo_half: 4'd2, oe: 1'b1, txc_kind: 4'd5},
      '{rmii: 1'b0, dce: 1'b0, fast: 1'b0, refo_half: 4'd2, oe: 1'b0, txc_kind: 4'd0},
      '{rmii: 1'b1, dce: 1'b1, fast: 1'b0, refo_half: 4'd1, oe: 1'b0, txc_kind: 4'd0}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic logic pick(input int w);
      case (w)
         0: return refo_clk;
         1: return mdc_clk;
         2: return txc_o;
         default: return rxc_o;
      endcase
   endfunction

   task automatic tick(input int w);
      if (w < 2) @(posedge sys_clk);
      else       @(posedge ref_clk);
      #1;
   endtask

   task automatic settle();
      repeat (20) @(posedge ref_clk);
      repeat (20) @(posedge sys_clk);
   endtask

   // Checks every completed high and low run of an output against the expected length.
   task automatic check_runs(input int w, input int n, input int exp, input string req);
      logic prev, v;
      int run = 0;
      int highs = 0;
      bit hi_ok = 1'b0;
      bit lo_ok = 1'b0;
      tick(w);
      prev = pick(w);
      run = 1;
      for (int i = 1; i < n; i++) begin
         tick(w);
         v = pick(w);
         if (v === prev) begin
            run++;
         end else begin
            if (prev === 1'b1 && hi_ok) begin
               check(run == exp, {req, " high run"}, run, exp);
               highs++;
            end
            if (prev === 1'b0 && lo_ok) check(run == exp, {req, " low run"}, run, exp);
            if (v === 1'b1) hi_ok = 1'b1;
            if (v === 1'b0) lo_ok = 1'b1;
            prev = v;
            run = 1;
         end
      end
      check(highs >= 1, {req, " pulses seen"}, highs, 1);
   endtask

   task automatic apply(input logic r, input logic d, input logic f);
      rmii_sel = r;
      dce_sel = d;
      fast_sel = f;
      settle();
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual 0 expected 1 (run completed)");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      // R6: reset state
      repeat (6) @(posedge ref_clk);
      #1;
      check({refo_clk, mdc_clk, txc_o, rxc_o} == 4'b0000, "R6 clocks low in reset",
            int'({refo_clk, mdc_clk, txc_o, rxc_o}), 0);
      check({txc_oe, rxc_oe} == 2'b00, "R6 enables off in reset", int'({txc_oe, rxc_oe}), 0);
      @(negedge sys_clk);
      rst = 1'b0;
      settle();

      // table of modes
      for (int k = 0; k < NV; k++) begin
         apply(VECS[k].rmii, VECS[k].dce, VECS[k].fast);
         check(txc_oe == VECS[k].oe, "R4 txc_oe", int'(txc_oe), int'(VECS[k].oe));
         check(rxc_oe == VECS[k].oe, "R4 rxc_oe", int'(rxc_oe), int'(VECS[k].oe));
         check_runs(0, 40, int'(VECS[k].refo_half), "R1 refo_clk");
         check_runs(1, 200, 30, "R2 mdc_clk");
         if (VECS[k].txc_kind == 4'd0) begin
            for (int i = 0; i < 30; i++) begin
               tick(2);
               check(!txc_o && !rxc_o, "R5 undriven clocks low", int'({txc_o, rxc_o}), 0);
            end
         end else if (VECS[k].txc_kind == 4'd15) begin
            for (int i = 0; i < 8; i++) begin
               @(posedge ref_clk);
               #2;
               check(txc_o && rxc_o, "R3 pass-through high phase", int'({txc_o, rxc_o}), 3);
               @(negedge ref_clk);
               #2;
               check(!txc_o && !rxc_o, "R3 pass-through low phase", int'({txc_o, rxc_o}), 0);
            end
         end else begin
            check_runs(2, 60, int'(VECS[k].txc_kind), "R3 txc_o slow");
            check_runs(3, 60, int'(VECS[k].txc_kind), "R3 rxc_o slow");
            for (int i = 0; i < 20; i++) begin
               tick(2);
               check(txc_o === rxc_o, "R3 rxc_o equals txc_o", int'(rxc_o), int'(txc_o));
            end
         end
      end

      // R7: re-enable from DTE into MII DCE 10 Mbit/s, window starts at the change
      apply(1'b0, 1'b0, 1'b0);
      dce_sel = 1'b1;
      check_runs(2, 60, 5, "R7 restart txc_o");

      // R6: reset in the middle of operation
      apply(1'b0, 1'b1, 1'b0);
      @(negedge sys_clk);
      rst = 1'b1;
      repeat (4) @(posedge ref_clk);
      #1;
      check({refo_clk, mdc_clk, txc_o, rxc_o} == 4'b0000, "R6 mid-run reset clocks low",
            int'({refo_clk, mdc_clk, txc_o, rxc_o}), 0);
      check({txc_oe, rxc_oe} == 2'b00, "R6 mid-run reset enables off", int'({txc_oe, rxc_oe}), 0);
      @(negedge sys_clk);
      rst = 1'b0;
      settle();
      check(txc_oe == 1'b1, "R4 enables return after reset", int'(txc_oe), 1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule